// File: doc/BRIEF.md
# I2C EEPROM Access Sequencer

This block sits between a requester that wants whole EEPROM transfers and an I2C master that accepts one command word per bus byte. Each command word carries a data byte, a read/write selector, a flag that forces a repeated START in front of the byte and a flag that ends the transfer with STOP. The sequencer accepts a single request: a direction, a 7-bit device address, a 16-bit memory address and a byte count. It turns that request into the command words a two-byte-addressed EEPROM expects. It then reports one result code when the request ends.

A write request sends both memory-address bytes and then the data bytes, which it takes one at a time from a byte stream. STOP follows the final byte. When the write succeeds, the block holds off new requests for a programmable write-cycle time so the memory can commit the data. A read request first sets the memory pointer with an address-only write that ends without STOP. It then issues read commands one at a time. The first read command carries a repeated START and the last carries STOP. Each returned byte goes out on a byte stream before the next read command is sent.

Faults reported by the master, and waits on the master that run too long, end the request. The block returns a result code that has one bit set for each kind of error. When the fault came from the master, the block also pulses a status-clear strobe toward it.

Top module: `eeprom_seq`

## Requirements
- R1: A write request emits, in this order: the high memory-address byte, the low memory-address byte, then `req_len` data bytes taken from the write stream. Every word has `cmd_read`=0 and `cmd_restart`=0. `cmd_stop` is 1 only on the final word, which is the low address byte when `req_len` is 0. `cmd_target` equals the device address of the request.
- R2: A read request first emits the two memory-address bytes, high then low, as write words with neither STOP nor RESTART. No read word is issued before the master reports its transmit queue empty. A read with `req_len`=0 ends with code 0 once that check passes.
- R3: The read phase emits `req_len` words with `cmd_read`=1. `cmd_restart` is 1 only on the first of these and `cmd_stop` is 1 only on the last. The received bytes appear on `rd_data` in order.
- R4: At most one read word is outstanding. The next read word is emitted only after the previous byte has been popped from the master (`m_rx_pop`) and accepted on the read stream.
- R5: When the master reports an empty transmit queue while `m_abort` is high, the request ends with code 2 if `m_nack_data` is set. Otherwise it ends with code 1 if `m_nack_addr` is set, and otherwise with code 0x10. In each of these cases `m_clr` pulses in the cycle before `done`.
- R6: The request ends with code 8 in three cases: a command word is not accepted, the transmit queue does not drain, or read data does not arrive, each within `TMO_CYC` cycles.
- R7: While the block waits for read data, `m_abort` together with `m_nack_addr` ends the request at once with code 1 and a `m_clr` pulse, and no further word is emitted.
- R8: `done` is a one-cycle pulse, raised exactly once per request, with the result on `done_err` (0 means success). `req_ready` is high only while the block is idle.
- R9: After a write ends with code 0, `req_ready` returns exactly `WCYC_CYC`+1 cycles after the `done` cycle. A request offered during that wait is ignored: it produces no command word and no `done`.
- R10: After reset, `req_ready`=1 and `cmd_valid`, `rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_dev | input | 7 | Device address on the bus |
| req_mem | input | 16 | Memory address inside the EEPROM |
| req_len | input | LEN_W | Number of data bytes |
| wd_valid | input | 1 | Write byte offered |
| wd_ready | output | 1 | Write byte taken |
| wd_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command word offered to the master |
| cmd_ready | input | 1 | Master accepts the word |
| cmd_data | output | 8 | Byte to send (0 for reads) |
| cmd_read | output | 1 | Word is a read |
| cmd_restart | output | 1 | Repeated START before this byte |
| cmd_stop | output | 1 | STOP after this byte |
| cmd_target | output | 7 | Device address for the master |
| m_tx_empty | input | 1 | Master transmit queue empty |
| m_rx_ne | input | 1 | Master receive queue holds a byte |
| m_rx_data | input | 8 | Head of master receive queue |
| m_rx_pop | output | 1 | Pop one received byte |
| m_abort | input | 1 | Master aborted the transfer |
| m_nack_addr | input | 1 | Abort cause: device address not acknowledged |
| m_nack_data | input | 1 | Abort cause: data byte not acknowledged |
| m_clr | output | 1 | Clear the master's abort status |
| done | output | 1 | Request finished (pulse) |
| done_err | output | 5 | Result code, bit per error kind |

## Verification
Command words, `wd_ready` and `m_rx_pop` are combinational, so they are due in the same cycle as the state and inputs that cause them. The bench therefore logs a handshake 1 ns after the falling edge, before the rising edge that completes it. `done` and `done_err` are registered and appear one cycle after the finishing event. `req_ready` comes back `WCYC_CYC`+1 cycles after `done` for a successful write and stays high in the `done` cycle otherwise. The bench counts falling edges from the `done` it saw and compares that count exactly. The master model runs in the same process as the checks. Its queue drain delay, receive latency, faults and stalls are set per request, so every expected word list and code is built from the request alone.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a request
    S_AWR,    // address and data write words
    S_TXW,    // waiting for transmit queue to drain
    S_RCMD,   // one read word
    S_RXW,    // waiting for the read byte
    S_RXO,    // offering the read byte downstream
    S_WCW     // post-write commit wait
  } seq_state_t;

  localparam logic [4:0] E_OK        = 5'h00;
  localparam logic [4:0] E_ADDR_NACK = 5'h01;
  localparam logic [4:0] E_DATA_NACK = 5'h02;
  localparam logic [4:0] E_TIMEOUT   = 5'h08;
  localparam logic [4:0] E_ABORT     = 5'h10;

  // data NACK outranks address NACK; an abort with neither is generic
  function automatic logic [4:0] abort_code(input logic nack_data, input logic nack_addr);
    if (nack_data)      return E_DATA_NACK;
    else if (nack_addr) return E_ADDR_NACK;
    else                return E_ABORT;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [15:0] mem, input logic low);
    return low ? mem[7:0] : mem[15:8];
  endfunction

  // last word of the address/data phase of a request
  function automatic logic wr_phase_last(input logic is_rd, input logic [1:0] ph,
                                         input logic zero_left, input logic one_left);
    if (is_rd) return ph == 2'd1;
    return (ph == 2'd1 && zero_left) || (ph == 2'd2 && one_left);
  endfunction

endpackage

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eeprom_seq_evt.sv
module eeprom_seq_evt
  import eeprom_seq_pkg::*;
(
  input  logic       in_txw,
  input  logic       in_rxw,
  input  logic       tx_empty,
  input  logic       rx_ne,
  input  logic       abort,
  input  logic       nack_a,
  input  logic       nack_d,
  input  logic       expired,
  output logic       fin,
  output logic [4:0] code,
  output logic       clr,
  output logic       pop
);
  always_comb begin
    fin  = 1'b0;
    code = E_OK;
    clr  = 1'b0;
    pop  = 1'b0;
    if (in_txw) begin
      if (tx_empty) begin
        fin = 1'b1;
        if (abort) begin
          code = abort_code(nack_d, nack_a);
          clr  = 1'b1;
        end
      end else if (expired) begin
        fin  = 1'b1;
        code = E_TIMEOUT;
      end
    end else if (in_rxw) begin
      if (abort && nack_a) begin
        fin  = 1'b1;
        code = E_ADDR_NACK;
        clr  = 1'b1;
      end else if (rx_ne) begin
        pop = 1'b1;
      end else if (expired) begin
        fin  = 1'b1;
        code = E_TIMEOUT;
      end
    end
  end
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int TMO_CYC  = 2000000,
  parameter int WCYC_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rd,
  input  logic [6:0]       req_dev,
  input  logic [15:0]      req_mem,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [7:0]       wd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [7:0]       cmd_data,
  output logic             cmd_read,
  output logic             cmd_restart,
  output logic             cmd_stop,
  output logic [6:0]       cmd_target,
  input  logic             m_tx_empty,
  input  logic             m_rx_ne,
  input  logic [7:0]       m_rx_data,
  output logic             m_rx_pop,
  input  logic             m_abort,
  input  logic             m_nack_addr,
  input  logic             m_nack_data,
  output logic             m_clr,
  output logic             done,
  output logic [4:0]       done_err
);
  localparam int TMAX = (TMO_CYC > WCYC_CYC) ? TMO_CYC : WCYC_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TMO_LD  = TW'(TMO_CYC);
  localparam logic [TW-1:0] WCYC_LD = TW'(WCYC_CYC);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

  seq_state_t       state_q, state_d;
  logic             rd_q;
  logic [6:0]       dev_q;
  logic [15:0]      mem_q;
  logic [LEN_W-1:0] rem_q;
  logic [1:0]       ph_q;
  logic             first_q;
  logic [7:0]       hold_q;
  logic             done_q;
  logic [4:0]       err_q;

  // named internal events
  logic       in_awr, in_rcmd, in_cmd, wr_last, cmd_fire, cmd_tmo;
  logic       ev_fin, ev_clr, ev_pop, expired, tmr_load;
  logic [4:0] ev_code;
  logic       fin;
  logic [4:0] fin_code;
  logic [TW-1:0] tmr_val;

  assign in_awr  = (state_q == S_AWR);
  assign in_rcmd = (state_q == S_RCMD);
  assign in_cmd  = in_awr | in_rcmd;
  assign wr_last = wr_phase_last(rd_q, ph_q, rem_q == '0, rem_q == ONE);

  assign cmd_valid   = in_rcmd | (in_awr & ((ph_q != 2'd2) | wd_valid));
  assign cmd_data    = in_awr ? ((ph_q == 2'd2) ? wd_data : addr_byte(mem_q, ph_q[0])) : 8'h00;
  assign cmd_read    = in_rcmd;
  assign cmd_restart = in_rcmd & first_q;
  assign cmd_stop    = in_rcmd ? (rem_q == ONE) : (in_awr & ~rd_q & wr_last);
  assign cmd_target  = dev_q;
  assign wd_ready    = in_awr & (ph_q == 2'd2) & cmd_ready;
  assign cmd_fire    = cmd_valid & cmd_ready;
  assign cmd_tmo     = in_cmd & cmd_valid & ~cmd_ready & expired;

  assign req_ready = (state_q == S_IDLE);
  assign rd_valid  = (state_q == S_RXO);
  assign rd_data   = hold_q;
  assign m_rx_pop  = ev_pop;
  assign m_clr     = ev_clr;
  assign done      = done_q;
  assign done_err  = err_q;

  eeprom_seq_evt i_evt (
    .in_txw   (state_q == S_TXW),
    .in_rxw   (state_q == S_RXW),
    .tx_empty (m_tx_empty),
    .rx_ne    (m_rx_ne),
    .abort    (m_abort),
    .nack_a   (m_nack_addr),
    .nack_d   (m_nack_data),
    .expired  (expired),
    .fin      (ev_fin),
    .code     (ev_code),
    .clr      (ev_clr),
    .pop      (ev_pop)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = E_OK;
    unique case (state_q)
      S_IDLE: if (req_valid) state_d = S_AWR;
      S_AWR: begin
        if (cmd_fire) begin
          if (wr_last) state_d = S_TXW;
        end else if (cmd_tmo) begin
          fin = 1'b1; fin_code = E_TIMEOUT;
        end
      end
      S_TXW: begin
        if (ev_fin) begin
          if (ev_code != E_OK || !rd_q || rem_q == '0) begin
            fin = 1'b1; fin_code = ev_code;
          end else begin
            state_d = S_RCMD;
          end
        end
      end
      S_RCMD: begin
        if (cmd_fire)     state_d = S_RXW;
        else if (cmd_tmo) begin fin = 1'b1; fin_code = E_TIMEOUT; end
      end
      S_RXW: begin
        if (ev_fin)      begin fin = 1'b1; fin_code = ev_code; end
        else if (ev_pop) state_d = S_RXO;
      end
      S_RXO: begin
        if (rd_ready) begin
          if (rem_q == ONE) begin fin = 1'b1; fin_code = E_OK; end
          else state_d = S_RCMD;
        end
      end
      S_WCW: if (expired) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = (!rd_q && fin_code == E_OK) ? S_WCW : S_IDLE;
  end

  assign tmr_load = (state_d != state_q) | cmd_fire | (in_cmd & ~cmd_valid);
  assign tmr_val  = (state_d == S_WCW) ? WCYC_LD : TMO_LD;

  eeprom_seq_timer #(.W(TW)) i_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
      dev_q   <= '0;
      mem_q   <= '0;
      rem_q   <= '0;
      ph_q    <= '0;
      first_q <= 1'b0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) err_q <= fin_code;
      if (state_q == S_IDLE && req_valid) begin
        rd_q    <= req_rd;
        dev_q   <= req_dev;
        mem_q   <= req_mem;
        rem_q   <= req_len;
        ph_q    <= 2'd0;
        first_q <= 1'b1;
      end
      if (in_awr && cmd_fire) begin
        if (ph_q == 2'd2) rem_q <= rem_q - ONE;
        else              ph_q  <= ph_q + 2'd1;
      end
      if (in_rcmd && cmd_fire) first_q <= 1'b0;
      if (ev_pop) hold_q <= m_rx_data;
      if (state_q == S_RXO && rd_ready) rem_q <= rem_q - ONE;
    end
  end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_read,
  input logic       cmd_restart,
  input logic       m_rx_pop,
  input logic       m_clr,
  input logic       done,
  input logic [4:0] done_err,
  input logic       rd_q
);
  logic [1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  outst_q <= '0;
    else if (done)                               outst_q <= '0;
    else if (cmd_valid && cmd_ready && cmd_read) outst_q <= outst_q + 2'd1;
    else if (m_rx_pop && outst_q != '0)          outst_q <= outst_q - 2'd1;
  end

  p_no_restart_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_read |-> !cmd_restart);

  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_read |-> outst_q == 2'd0);

  p_err_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(done_err));

  p_clr_reports_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_clr |=> done && done_err != 5'h00 && done_err != 5'h08);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  p_wait_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err == 5'h00 && !rd_q |-> !req_ready);
endmodule

bind eeprom_seq eeprom_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_read    (cmd_read),
  .cmd_restart (cmd_restart),
  .m_rx_pop    (m_rx_pop),
  .m_clr       (m_clr),
  .done        (done),
  .done_err    (done_err),
  .rd_q        (rd_q)
);

// File: tb/test_eeprom_seq.sv
module test_eeprom_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int TMO   = 16;
  localparam int WCYC  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [6:0] req_dev = '0;
  logic [15:0] req_mem = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wd_valid = 1'b0;
  logic [7:0] wd_data = '0;
  logic rd_ready = 1'b1, cmd_ready = 1'b1;
  logic m_tx_empty = 1'b1, m_rx_ne = 1'b0;
  logic [7:0] m_rx_data = '0;
  logic m_abort = 1'b0, m_nack_addr = 1'b0, m_nack_data = 1'b0;
  logic req_ready, wd_ready, rd_valid, cmd_valid, cmd_read, cmd_restart, cmd_stop;
  logic m_rx_pop, m_clr, done;
  logic [7:0] rd_data, cmd_data;
  logic [6:0] cmd_target;
  logic [4:0] done_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_seq #(.LEN_W(LEN_W), .TMO_CYC(TMO), .WCYC_CYC(WCYC)) i_eeprom_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd), .req_dev(req_dev),
    .req_mem(req_mem), .req_len(req_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_read(cmd_read),
    .cmd_restart(cmd_restart), .cmd_stop(cmd_stop), .cmd_target(cmd_target),
    .m_tx_empty(m_tx_empty), .m_rx_ne(m_rx_ne), .m_rx_data(m_rx_data), .m_rx_pop(m_rx_pop),
    .m_abort(m_abort), .m_nack_addr(m_nack_addr), .m_nack_data(m_nack_data), .m_clr(m_clr),
    .done(done), .done_err(done_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  // master model state
  int mode = 0, wi = 0, wn = 0, txbusy = 0, rxdly = 0, rx_k = 0;
  bit stall = 0, ab6 = 0, p_wd = 0, p_cmdw = 0, p_cmdr = 0, p_pop = 0;
  logic [7:0] wbuf [16];
  // observation logs
  logic [7:0] lg_d [16];
  logic lg_r [16], lg_s [16], lg_t [16];
  logic [6:0] lg_tg [16];
  int lg_n = 0;
  logic [7:0] rdb [16];
  int rd_n = 0, clr_n = 0, done_n = 0, r4_out = 0, r4_pend = 0, r4_bad = 0;
  logic [4:0] last_err = '0;
  // expected command list
  logic [7:0] e_d [16];
  logic e_r [16], e_s [16], e_t [16];
  int en = 0;

  function automatic logic [7:0] rxpat(input int k);
    return 8'(8'h3C + k * 29);
  endfunction
  function automatic logic [7:0] wpat(input int j, input logic [15:0] mem);
    return mem[7:0] ^ 8'(j * 53 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic r, input logic s, input logic t);
    e_d[en] = d; e_r[en] = r; e_s[en] = s; e_t[en] = t; en++;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (p_wd) wi++;
    wd_valid = (wi < wn);
    wd_data  = (wi < 16) ? wbuf[wi] : 8'h00;
    if (p_cmdw) txbusy = 3; else if (txbusy > 0) txbusy--;
    if (p_pop) m_rx_ne = 1'b0;
    if (p_cmdr) begin
      if (mode == 6) ab6 = 1; else if (mode != 5) rxdly = 3;
    end else if (rxdly > 0) begin
      rxdly--;
      if (rxdly == 0) begin m_rx_ne = 1'b1; m_rx_data = rxpat(rx_k); rx_k++; end
    end
    m_tx_empty  = (txbusy == 0) && (mode != 4);
    m_abort     = (mode >= 1 && mode <= 3) || ab6;
    m_nack_addr = (mode == 1) || (mode == 2) || ab6;
    m_nack_data = (mode == 2);
    cmd_ready   = (mode != 7) && !(stall && (cyc % 3 == 0));
    rd_ready    = !(stall && (cyc % 4 == 1));
    #1;
    p_pop  = m_rx_pop;
    p_cmdw = cmd_valid && cmd_ready && !cmd_read;
    p_cmdr = cmd_valid && cmd_ready && cmd_read;
    p_wd   = wd_valid && wd_ready;
    if (cmd_valid && cmd_ready && lg_n < 16) begin
      lg_d[lg_n] = cmd_data; lg_r[lg_n] = cmd_read; lg_s[lg_n] = cmd_restart;
      lg_t[lg_n] = cmd_stop; lg_tg[lg_n] = cmd_target; lg_n++;
    end
    if (p_cmdr) begin
      if (r4_out != 0 || r4_pend != 0) r4_bad++;
      r4_out++;
    end
    if (p_pop) begin r4_out--; r4_pend = 1; end
    if (rd_valid && rd_ready) begin
      if (rd_n < 16) rdb[rd_n] = rd_data;
      rd_n++; r4_pend = 0;
    end
    if (m_clr) clr_n++;
    if (done) begin done_n++; last_err = done_err; end
  endtask

  task automatic run_req(input bit rd, input logic [6:0] dev, input logic [15:0] mem,
                         input int len, input int md, input bit stl, input bit poke);
    int exp_err, exp_clr, nrd, k;
    bool_dummy: begin end
    mode = md; stall = stl; ab6 = 0; lg_n = 0; rd_n = 0; clr_n = 0; done_n = 0;
    rx_k = 0; wi = 0; wn = rd ? 0 : len; r4_out = 0; r4_pend = 0; r4_bad = 0;
    for (int j = 0; j < 16; j++) wbuf[j] = wpat(j, mem);
    while (!req_ready) tick();
    req_rd = rd; req_dev = dev; req_mem = mem; req_len = LEN_W'(len); req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    for (int c = 0; c < 300 && done_n == 0; c++) tick();
    // expected command list
    en = 0;
    if (md != 7) begin
      push(mem[15:8], 0, 0, 0);
      push(mem[7:0], 0, 0, !rd && len == 0);
      if (!rd && md <= 4) for (int j = 0; j < len; j++) push(wpat(j, mem), 0, 0, j == len - 1);
    end
    nrd = 0;
    if (rd && md == 0) nrd = len;
    if (rd && (md == 5 || md == 6) && len > 0) nrd = 1;
    for (int j = 0; j < nrd; j++) push(8'h00, 1, j == 0, j == len - 1);
    case (md)
      0: exp_err = 0; 1: exp_err = 1; 2: exp_err = 2; 3: exp_err = 16;
      6: exp_err = (len > 0) ? 1 : 0;
      default: exp_err = 8;
    endcase
    exp_clr = (md >= 1 && md <= 3) || (md == 6 && len > 0) ? 1 : 0;
    chk(done_n == 1, "R8 done count", done_n, 1);
    if (md == 1 || md == 2 || md == 3) chk(last_err == 5'(exp_err), "R5 abort code", last_err, exp_err);
    else if (md == 6) chk(last_err == 5'(exp_err), "R7 read address nack code", last_err, exp_err);
    else if (md >= 4) chk(last_err == 5'(exp_err), "R6 timeout code", last_err, exp_err);
    else chk(last_err == 5'(exp_err), "R8 success code", last_err, exp_err);
    chk(clr_n == exp_clr, "R5 status clear pulses", clr_n, exp_clr);
    chk(lg_n == en, rd ? "R2 read command count" : "R1 write command count", lg_n, en);
    for (int j = 0; j < en && j < lg_n; j++) begin
      chk(lg_r[j] == e_r[j] && lg_s[j] == e_s[j] && lg_t[j] == e_t[j],
          (e_r[j] ? "R3 read word flags" : (rd ? "R2 address word flags" : "R1 write word flags")),
          {lg_r[j], lg_s[j], lg_t[j]}, {e_r[j], e_s[j], e_t[j]});
      if (!e_r[j]) chk(lg_d[j] == e_d[j], rd ? "R2 address byte" : "R1 data byte", lg_d[j], e_d[j]);
      chk(lg_tg[j] == dev, "R1 target address", lg_tg[j], dev);
    end
    if (rd && md == 0) begin
      chk(rd_n == len, "R3 read byte count", rd_n, len);
      for (int j = 0; j < len && j < rd_n; j++) chk(rdb[j] == rxpat(j), "R3 read byte value", rdb[j], rxpat(j));
    end
    if (rd) chk(r4_bad == 0, "R4 read outstanding", r4_bad, 0);
    if (!rd && md == 0) begin
      chk(req_ready == 1'b0, "R9 busy in done cycle", req_ready, 0);
      lg_n = 0; done_n = 0; k = 0;
      while (!req_ready && k < 200) begin
        if (poke && k < WCYC - 4) begin
          req_rd = 1'b1; req_len = LEN_W'(2); req_valid = 1'b1;
        end else req_valid = 1'b0;
        tick(); k++;
      end
      req_valid = 1'b0;
      chk(k == WCYC + 1, "R9 write-cycle wait length", k, WCYC + 1);
      if (poke) begin
        for (int c = 0; c < 3; c++) tick();
        chk(lg_n == 0, "R9 ignored request words", lg_n, 0);
        chk(done_n == 0, "R9 ignored request done", done_n, 0);
      end
    end else begin
      chk(req_ready == 1'b1, "R8 idle in done cycle", req_ready, 1);
    end
    mode = 0; tick(); tick();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", c_dummy(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end
  function automatic int c_dummy();
    return 1;
  endfunction

  initial begin : main
    for (int c = 0; c < 3; c++) tick();
    rst_n = 1'b1;
    tick();
    chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R10 reset cmd_valid", cmd_valid, 0);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", rd_valid, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    for (int len = 0; len < 4; len++)
      run_req(0, 7'h50 + 7'(len), 16'h1200 + 16'(len * 33), len, 0, len[0], len == 2);
    for (int len = 0; len < 5; len++)
      run_req(1, 7'h51, 16'hA0C3 + 16'(len), len, 0, len[0], 0);
    for (int md = 1; md <= 4; md++) run_req(0, 7'h2A, 16'h0F0F, 2, md, 0, 0);
    run_req(0, 7'h2B, 16'h0101, 1, 7, 0, 0);
    for (int md = 1; md <= 7; md++) if (md != 2) run_req(1, 7'h33, 16'h7E81, 3, md, 0, 0);
    run_req(1, 7'h34, 16'h4455, 1, 6, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule